// File: doc/BRIEF.md
# Indexed Link Register Window

This block is a small I/O-mapped window that reaches the per-port link registers of a two-port serial storage controller by indirection. Software writes a pointer word that names a port and one of three link registers (status, control, error). Each later read or write of a second word is then carried out on the register that the pointer names. The second word has no storage of its own, so its value, including its value just after reset, is always the value of the register the pointer selects.

The window has four 32-bit dword slots, chosen by a 2-bit dword address. Slot 0 holds the pointer. Slot 1 is the pass-through data word. Slots 2 and 3 are reserved. A mode pair gates the whole window: it answers only when the legacy IDE programming interface is selected and combined mode is off. The per-port register model sits inside the block. Status follows a live input per port. Control is plain read/write storage. Error bits are set by hardware pulses and cleared when software writes ones to them.

Top module: `link_reg_window`

## Requirements
- R1: The pointer (slot 0) resets to 00000000h. Bits 15:0 read back what was written. Bits 31:16 always read zero and ignore writes.
- R2: Writes to the pointer and to the data word change only the bytes whose `io_be` bit is set (bit n covers data bits 8n+7:8n).
- R3: A read of slot 1 returns the selected register. Pointer bits 7:0 pick it: 00h is status (the port's `link_status` slice, live), 01h is control, 02h is error.
- R4: Pointer bits 15:8 pick the port: 00h is port 0 and 02h is port 1. A data write changes only the selected port's register.
- R5: Status is read-only through the window. Data writes to it leave it unchanged.
- R6: Error bits are set by a one-cycle `err_set` bit and cleared by writing one to them through slot 1. A set and a clear of the same bit in the same cycle leave the bit set.
- R7: When the pointer holds a reserved port code or a reserved register code, a slot-1 read returns zero and a slot-1 write changes no register.
- R8: Slots 2 and 3 read zero, and writes to them change nothing.
- R9: When `mode_ide` is 0 or `mode_combined` is 1, every read returns zero and every write is ignored.
- R10: After reset, with the pointer at zero, slot 1 reads port 0's status input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_ide | input | 1 | 1 when the legacy IDE programming interface is selected |
| mode_combined | input | 1 | 1 when combined mode is active |
| io_en | input | 1 | Access strobe, one cycle per access |
| io_wr | input | 1 | 1 = write, 0 = read |
| io_addr | input | 2 | Dword slot: 0 pointer, 1 data, 2 and 3 reserved |
| io_be | input | 4 | Byte enables for writes |
| io_wdata | input | 32 | Write data |
| io_rdata | output | 32 | Read data, valid in the same cycle as the read strobe |
| link_status | input | 64 | Status value per port, port p in bits 32p+31:32p |
| err_set | input | 64 | Error set pulses per port, same layout |

## Verification
Software-style access sequences go through the window with the pointer stepped over every legal port and register pair. They use distinct data patterns per port, so a write that reaches the wrong port or register shows up as a wrong value on a later read. Full-word and single-byte writes tell correct byte masking apart from whole-word overwrite. Reserved port codes, reserved register codes and reserved slots are each followed by reads of the legal registers, which shows that nothing was written through them. Error pulses overlapping with write-one-to-clear, and accesses made with each mode input in its disabling state, separate the priority and gating rules from plain storage.

// File: rtl/lrw_pkg.sv
`timescale 1ns/1ps
package lrw_pkg;
  // dword slot inside the window
  typedef enum logic [1:0] {
    SLOT_PTR  = 2'd0,
    SLOT_DATA = 2'd1,
    SLOT_RSV0 = 2'd2,
    SLOT_RSV1 = 2'd3
  } slot_e;

  // decoded link register selector
  typedef enum logic [1:0] {
    LR_STAT = 2'd0,
    LR_CTRL = 2'd1,
    LR_ERR  = 2'd2,
    LR_NONE = 2'd3
  } lreg_e;

  localparam logic [7:0] CODE_STAT = 8'h00;
  localparam logic [7:0] CODE_CTRL = 8'h01;
  localparam logic [7:0] CODE_ERR  = 8'h02;
endpackage

// File: rtl/lrw_rst_sync.sv
`timescale 1ns/1ps
module lrw_rst_sync (
  input  logic clk,
  input  logic rst_n_a,
  output logic rst_n_s
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_a) begin
    if (!rst_n_a) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_s = sync_q[1];
endmodule

// File: rtl/lrw_pointer.sv
`timescale 1ns/1ps
module lrw_pointer #(
  parameter int NPORT       = 2,
  parameter int PORT_STRIDE = 2,
  parameter int PW          = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [1:0]         be,
  input  logic [15:0]        wdata,
  output logic [15:0]        ptr_q,
  output logic               sel_ok,
  output logic [PW-1:0]      sel_port,
  output lrw_pkg::lreg_e     sel_reg
);
  import lrw_pkg::*;

  localparam logic [7:0] STRIDE8 = 8'(PORT_STRIDE);
  localparam logic [7:0] NPORT8  = 8'(NPORT);

  logic [15:0] ptr_d;
  logic [7:0]  pcode, pquot, prem;
  logic        port_ok;

  // next state: byte-masked update
  always_comb begin
    ptr_d = ptr_q;
    for (int b = 0; b < 2; b++) begin
      if (be[b]) ptr_d[8*b +: 8] = wdata[8*b +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  ptr_q <= '0;
    else if (we) ptr_q <= ptr_d;
  end

  // port code decode: multiples of the stride below the port count
  always_comb begin
    pcode    = ptr_q[15:8];
    pquot    = pcode / STRIDE8;
    prem     = pcode % STRIDE8;
    port_ok  = (prem == 8'd0) && (pquot < NPORT8);
    sel_port = pquot[PW-1:0];
  end

  // register code decode
  always_comb begin
    unique case (ptr_q[7:0])
      CODE_STAT: sel_reg = LR_STAT;
      CODE_CTRL: sel_reg = LR_CTRL;
      CODE_ERR:  sel_reg = LR_ERR;
      default:   sel_reg = LR_NONE;
    endcase
    sel_ok = port_ok && (sel_reg != LR_NONE);
  end

  // R1: pointer only moves on a pointer write
  a_r1_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(ptr_q));

  // R7: a valid selection never carries a register code above the error code
  a_r7_code_range: assert property (@(posedge clk) disable iff (!rst_n)
    sel_ok |-> (ptr_q[7:0] <= CODE_ERR));
endmodule

// File: rtl/lrw_port_regs.sv
`timescale 1ns/1ps
module lrw_port_regs #(
  parameter int DW = 32,
  localparam int NB = DW / 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  lrw_pkg::lreg_e  sel_reg,
  input  logic [NB-1:0]   be,
  input  logic [DW-1:0]   wdata,
  input  logic [DW-1:0]   sts_in,
  input  logic [DW-1:0]   err_set,
  output logic [DW-1:0]   rd_data
);
  import lrw_pkg::*;

  logic [DW-1:0] ctl_q, ctl_d, err_q, err_d, bmask;
  logic          ctl_en, err_en;

  always_comb begin
    for (int b = 0; b < NB; b++) bmask[8*b +: 8] = {8{be[b]}};
  end

  // next-state logic
  always_comb begin
    ctl_en = we && (sel_reg == LR_CTRL);
    ctl_d  = (ctl_q & ~bmask) | (wdata & bmask);
    err_en = (we && (sel_reg == LR_ERR)) || (|err_set);
    err_d  = err_q;
    if (we && (sel_reg == LR_ERR)) err_d = err_d & ~(wdata & bmask);
    err_d  = err_d | err_set;   // hardware set wins over clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_en) ctl_q <= ctl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      err_q <= '0;
    else if (err_en) err_q <= err_d;
  end

  always_comb begin
    unique case (sel_reg)
      LR_STAT: rd_data = sts_in;
      LR_CTRL: rd_data = ctl_q;
      LR_ERR:  rd_data = err_q;
      default: rd_data = '0;
    endcase
  end

  // R4: control unchanged unless this port is written
  a_r4_ctl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(ctl_q));

  // R6: every pulsed error bit is set on the next cycle
  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|err_set) |=> ((err_q & $past(err_set)) == $past(err_set)));

  // R6: error bits stay put with no pulse and no write
  a_r6_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!we && !(|err_set)) |=> $stable(err_q));
endmodule

// File: rtl/link_reg_window.sv
`timescale 1ns/1ps
module link_reg_window #(
  parameter int NPORT       = 2,
  parameter int PORT_STRIDE = 2,
  parameter int DW          = 32,
  localparam int NB         = DW / 8,
  localparam int PW         = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  mode_ide,
  input  logic                  mode_combined,
  input  logic                  io_en,
  input  logic                  io_wr,
  input  logic [1:0]            io_addr,
  input  logic [NB-1:0]         io_be,
  input  logic [DW-1:0]         io_wdata,
  output logic [DW-1:0]         io_rdata,
  input  logic [NPORT*DW-1:0]   link_status,
  input  logic [NPORT*DW-1:0]   err_set
);
  import lrw_pkg::*;

  logic          rst_sn;
  logic          win_en, acc_ok;
  logic          ptr_we, dat_we;
  slot_e         slot;
  logic [15:0]   ptr_val;
  logic          sel_ok;
  logic [PW-1:0] sel_port;
  lreg_e         sel_reg;
  logic [NPORT-1:0] port_we;
  logic [DW-1:0] port_rd [NPORT];

  lrw_rst_sync u_rst (
    .clk     (clk),
    .rst_n_a (rst_n),
    .rst_n_s (rst_sn)
  );

  // window gating and slot decode
  always_comb begin
    win_en = mode_ide && !mode_combined;
    acc_ok = win_en && io_en;
    slot   = slot_e'(io_addr);
    ptr_we = acc_ok && io_wr && (slot == SLOT_PTR);
    dat_we = acc_ok && io_wr && (slot == SLOT_DATA);
  end

  lrw_pointer #(
    .NPORT       (NPORT),
    .PORT_STRIDE (PORT_STRIDE),
    .PW          (PW)
  ) u_ptr (
    .clk      (clk),
    .rst_n    (rst_sn),
    .we       (ptr_we),
    .be       (io_be[1:0]),
    .wdata    (io_wdata[15:0]),
    .ptr_q    (ptr_val),
    .sel_ok   (sel_ok),
    .sel_port (sel_port),
    .sel_reg  (sel_reg)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    assign port_we[p] = dat_we && sel_ok && (sel_port == PW'(p));

    lrw_port_regs #(.DW(DW)) u_regs (
      .clk     (clk),
      .rst_n   (rst_sn),
      .we      (port_we[p]),
      .sel_reg (sel_reg),
      .be      (io_be),
      .wdata   (io_wdata),
      .sts_in  (link_status[p*DW +: DW]),
      .err_set (err_set[p*DW +: DW]),
      .rd_data (port_rd[p])
    );
  end

  // read return
  always_comb begin
    io_rdata = '0;
    if (acc_ok && !io_wr) begin
      unique case (slot)
        SLOT_PTR:  io_rdata = {{(DW-16){1'b0}}, ptr_val};
        SLOT_DATA: io_rdata = sel_ok ? port_rd[sel_port] : '0;
        default:   io_rdata = '0;
      endcase
    end
  end

  // R9: a write while the window is off leaves the pointer alone
  a_r9_off_no_write: assert property (@(posedge clk) disable iff (!rst_sn)
    (!win_en && io_en && io_wr) |=> $stable(ptr_val));

  // R8: writes to reserved slots leave the pointer alone
  a_r8_rsvd_no_write: assert property (@(posedge clk) disable iff (!rst_sn)
    (io_en && io_wr && io_addr[1]) |=> $stable(ptr_val));

  // R7: an invalid selection never enables a port write
  a_r7_no_port_we: assert property (@(posedge clk) disable iff (!rst_sn)
    !sel_ok |-> (port_we == '0));

  // R4: at most one port is written per access
  a_r4_one_port: assert property (@(posedge clk) disable iff (!rst_sn)
    $onehot0(port_we));
endmodule

// File: tb/test_link_reg_window.sv
`timescale 1ns/1ps
module test_link_reg_window;
  logic        clk, rst_n, mode_ide, mode_combined;
  logic        io_en, io_wr;
  logic [1:0]  io_addr;
  logic [3:0]  io_be;
  logic [31:0] io_wdata, io_rdata;
  logic [63:0] link_status, err_set;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  link_reg_window i_link_reg_window (
    .clk(clk), .rst_n(rst_n), .mode_ide(mode_ide), .mode_combined(mode_combined),
    .io_en(io_en), .io_wr(io_wr), .io_addr(io_addr), .io_be(io_be),
    .io_wdata(io_wdata), .io_rdata(io_rdata),
    .link_status(link_status), .err_set(err_set)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;   // 200 MHz

  // {req[3:0], wr, slot[1:0], be[3:0], wdata[31:0], expected read[31:0]}
  localparam int NV = 32;
  localparam logic [74:0] VEC [NV] = '{
    {4'd1,  1'b0, 2'd0, 4'hF, 32'h0,         32'h0000_0000}, // R1 reset value
    {4'd10, 1'b0, 2'd1, 4'hF, 32'h0,         32'h0000_0113}, // R10 status of port 0
    {4'd1,  1'b1, 2'd0, 4'hF, 32'hFFFF_0001, 32'h0},         // R1
    {4'd1,  1'b0, 2'd0, 4'hF, 32'h0,         32'h0000_0001}, // R1 upper zero
    {4'd3,  1'b1, 2'd1, 4'hF, 32'hA5A5_5A5A, 32'h0},         // R3
    {4'd3,  1'b0, 2'd1, 4'hF, 32'h0,         32'hA5A5_5A5A}, // R3 control
    {4'd2,  1'b1, 2'd1, 4'h1, 32'h0000_00FF, 32'h0},         // R2
    {4'd2,  1'b0, 2'd1, 4'hF, 32'h0,         32'hA5A5_5AFF}, // R2
    {4'd2,  1'b1, 2'd0, 4'h2, 32'h0000_0200, 32'h0},         // R2 pointer byte 1
    {4'd2,  1'b0, 2'd0, 4'hF, 32'h0,         32'h0000_0201}, // R2
    {4'd4,  1'b0, 2'd1, 4'hF, 32'h0,         32'h0000_0000}, // R4 port 1 control reset
    {4'd4,  1'b1, 2'd1, 4'hF, 32'h1234_5678, 32'h0},         // R4
    {4'd4,  1'b0, 2'd1, 4'hF, 32'h0,         32'h1234_5678}, // R4
    {4'd3,  1'b1, 2'd0, 4'hF, 32'h0000_0200, 32'h0},         // R3
    {4'd3,  1'b0, 2'd1, 4'hF, 32'h0,         32'h0000_0123}, // R3 status of port 1
    {4'd5,  1'b1, 2'd1, 4'hF, 32'hFFFF_FFFF, 32'h0},         // R5
    {4'd5,  1'b0, 2'd1, 4'hF, 32'h0,         32'h0000_0123}, // R5
    {4'd7,  1'b1, 2'd0, 4'hF, 32'h0000_0101, 32'h0},         // R7 reserved port
    {4'd7,  1'b0, 2'd1, 4'hF, 32'h0,         32'h0000_0000}, // R7
    {4'd7,  1'b1, 2'd1, 4'hF, 32'hDEAD_BEEF, 32'h0},         // R7
    {4'd7,  1'b1, 2'd0, 4'hF, 32'h0000_0003, 32'h0},         // R7 reserved register
    {4'd7,  1'b0, 2'd1, 4'hF, 32'h0,         32'h0000_0000}, // R7
    {4'd7,  1'b1, 2'd1, 4'hF, 32'hCAFE_F00D, 32'h0},         // R7
    {4'd7,  1'b1, 2'd0, 4'hF, 32'h0000_0001, 32'h0},         // R7
    {4'd7,  1'b0, 2'd1, 4'hF, 32'h0,         32'hA5A5_5AFF}, // R7 port 0 control intact
    {4'd8,  1'b1, 2'd2, 4'hF, 32'hFFFF_FFFF, 32'h0},         // R8
    {4'd8,  1'b1, 2'd3, 4'hF, 32'hFFFF_FFFF, 32'h0},         // R8
    {4'd8,  1'b0, 2'd2, 4'hF, 32'h0,         32'h0000_0000}, // R8
    {4'd8,  1'b0, 2'd3, 4'hF, 32'h0,         32'h0000_0000}, // R8
    {4'd8,  1'b0, 2'd0, 4'hF, 32'h0,         32'h0000_0001}, // R8 pointer intact
    {4'd7,  1'b1, 2'd0, 4'hF, 32'h0000_0201, 32'h0},         // R7
    {4'd7,  1'b0, 2'd1, 4'hF, 32'h0,         32'h1234_5678}  // R7 port 1 control intact
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", req, act, exp);
    end
  endtask

  // called just after a falling edge; returns one cycle later, just after the next one
  task automatic acc(input logic wr, input logic [1:0] a, input logic [3:0] be,
                     input logic [31:0] wd, output logic [31:0] rd);
    io_en = 1'b1; io_wr = wr; io_addr = a; io_be = be; io_wdata = wd;
    #1 rd = io_rdata;
    @(negedge clk);
    io_en = 1'b0; io_wr = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    rst_n = 1'b0; mode_ide = 1'b1; mode_combined = 1'b0;
    io_en = 1'b0; io_wr = 1'b0; io_addr = 2'd0; io_be = 4'h0; io_wdata = '0;
    link_status = {32'h0000_0123, 32'h0000_0113};
    err_set = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [74:0] v;
      v = VEC[i];
      acc(v[70], v[69:68], v[67:64], v[63:32], rd);
      if (!v[70]) begin
        checks++;
        if (rd !== v[31:0]) begin
          errors++;
          $display("FAIL R%0d vec %0d: got %08h expected %08h", v[74:71], i, rd, v[31:0]);
        end
      end
    end

    // R6 error register: hardware set, write-one-to-clear, set wins
    acc(1'b1, 2'd0, 4'hF, 32'h0000_0002, rd);
    err_set[31:0] = 32'h0000_F00F;
    @(negedge clk);
    err_set = '0;
    acc(1'b0, 2'd1, 4'hF, 32'h0, rd);
    check("R6 set", rd, 32'h0000_F00F);
    acc(1'b1, 2'd1, 4'h1, 32'h0000_000F, rd);
    acc(1'b0, 2'd1, 4'hF, 32'h0, rd);
    check("R6 clear byte0", rd, 32'h0000_F000);
    err_set[31:0] = 32'h0000_1000;
    acc(1'b1, 2'd1, 4'hF, 32'h0000_1000, rd);
    err_set = '0;
    acc(1'b0, 2'd1, 4'hF, 32'h0, rd);
    check("R6 set wins", rd, 32'h0000_F000);
    acc(1'b1, 2'd1, 4'h2, 32'hFFFF_FFFF, rd);
    acc(1'b0, 2'd1, 4'hF, 32'h0, rd);
    check("R6 clear byte1", rd, 32'h0000_0000);
    acc(1'b1, 2'd0, 4'hF, 32'h0000_0202, rd);
    acc(1'b0, 2'd1, 4'hF, 32'h0, rd);
    check("R4 port 1 error untouched", rd, 32'h0000_0000);

    // R3 status is live
    acc(1'b1, 2'd0, 4'hF, 32'h0000_0000, rd);
    link_status[31:0] = 32'hABCD_0001;
    acc(1'b0, 2'd1, 4'hF, 32'h0, rd);
    check("R3 live status", rd, 32'hABCD_0001);

    // R9 gating by each mode input
    mode_ide = 1'b0;
    acc(1'b0, 2'd1, 4'hF, 32'h0, rd);
    check("R9 ide off read", rd, 32'h0);
    acc(1'b1, 2'd0, 4'hF, 32'h0000_0001, rd);
    mode_ide = 1'b1;
    acc(1'b0, 2'd0, 4'hF, 32'h0, rd);
    check("R9 ide off write ignored", rd, 32'h0);
    mode_combined = 1'b1;
    acc(1'b1, 2'd0, 4'hF, 32'h0000_0001, rd);
    acc(1'b0, 2'd0, 4'hF, 32'h0, rd);
    check("R9 combined read", rd, 32'h0);
    mode_combined = 1'b0;
    acc(1'b0, 2'd0, 4'hF, 32'h0, rd);
    check("R9 combined write ignored", rd, 32'h0);
    acc(1'b1, 2'd0, 4'hF, 32'h0000_0001, rd);
    mode_combined = 1'b1;
    acc(1'b1, 2'd1, 4'hF, 32'h1111_1111, rd);
    mode_combined = 1'b0;
    acc(1'b0, 2'd1, 4'hF, 32'h0, rd);
    check("R9 data write ignored", rd, 32'hA5A5_5AFF);

    finish_run();
  end
endmodule